// File: doc/BRIEF.md
# Rounded Baud Tick Generator

This block turns a requested serial bit rate, given as an integer number of bits per second, into a stream of one-cycle tick pulses derived from a fixed 48 MHz clock. A request is first limited to the supported span of 300 bps to 2 Mbps. A prescale factor is then picked from the limited rate: 4 for slow rates and 1 for all others. The block works out the divider as the rounded quotient of the clock frequency over twice the prescale times the rate. A bit-serial integer divider does this work. When the result is in place, the block raises `ready`. It then counts down from the tick period and reports the divider and prescale it settled on.

A UART framer would use `tick` as its bit-time strobe. It can also read back `divider` and `prescale` to work out the true bit rate, which is 48 MHz / (2 × prescale × divider). This can differ slightly from the request. A new request may arrive at any time. It abandons any computation in progress, silences the ticks and starts a fresh calculation.

Control states: `CTL_IDLE` (after reset, no rate known) moves to `CTL_LOAD` on a request. `CTL_LOAD` (divider started) moves to `CTL_DIVIDE`. `CTL_DIVIDE` (waiting for the quotient) moves to `CTL_RUN` when the divider signals completion. `CTL_RUN` (ticking) stays in place. A request in any state returns to `CTL_LOAD`. Divider states: `DV_IDLE` goes to `DV_STEP` on start. `DV_STEP` performs one quotient bit per cycle and moves to `DV_DONE` after the last bit. `DV_DONE` goes to `DV_IDLE`. A start in any divider state reloads the divider and enters `DV_STEP`.

Top module: `btg_top`

## Requirements
- R1: While reset is held and right after it, `ready` and `tick` are 0, and `divider` and `prescale` read 0.
- R2: A requested rate below 300 is treated as 300, and one above 2,000,000 is treated as 2,000,000.
- R3: After limiting, the reported prescale is 4 when the rate is at most 365 and 1 when it is above 365.
- R4: The reported divider equals floor((48,000,000 + p·r) / (2·p·r)) for limited rate r and prescale p, which is the quotient rounded to nearest with halves rounded up. It is never 0 once ready.
- R5: `ready` rises on the 34th rising clock edge after the edge that samples `req_valid` high (the data path is 32 bits wide). `divider` and `prescale` change only on that edge.
- R6: While ready, `tick` is a one-cycle pulse. It is high in the P-th ready cycle and then in every P-th cycle after that, where P = 2·p·divider.
- R7: A request sampled while computing or ticking drops `ready` from the next cycle and restarts the calculation. The old `divider` and `prescale` values stay visible until the new result is ready.
- R8: `tick` is never high while `ready` is low.
- R9: Whenever `ready` is high, `prescale` reads 1 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe that starts a new rate request |
| req_rate | input | RATE_W (24) | Requested bit rate in bits per second |
| ready | output | 1 | Divider result valid and ticks running |
| tick | output | 1 | One-cycle bit-time strobe |
| divider | output | DIV_W (17) | Divider currently in use |
| prescale | output | PRE_W (3) | Prescale currently in use (1 or 4) |

## Verification
The hardest case to reach from the ports is a request that lands while the serial divider is partway through an earlier quotient. The stale completion must not leak into the outputs, and the values that were showing before must stay visible. The stimulus issues a request, waits about a third of the division time, then issues a second request with a very different rate. The reference model then expects only the second result, exactly 34 edges after the second strobe. A request issued while ticks are running checks the same hold-and-silence behaviour from the running state. The threshold pair 365/366 shows both the prescale switch and the largest divider width.

// File: rtl/btg_pkg.sv
package btg_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_LOAD,
        CTL_DIVIDE,
        CTL_RUN
    } ctl_state_e;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_STEP,
        DV_DONE
    } div_state_e;

endpackage

// File: rtl/btg_req_shaper.sv
module btg_req_shaper #(
    parameter int RATE_W     = 24,
    parameter int PRE_W      = 3,
    parameter int MIN_RATE   = 300,
    parameter int MAX_RATE   = 2_000_000,
    parameter int SLOW_LIMIT = 365,
    parameter int SLOW_PRE   = 4
) (
    input  logic [RATE_W-1:0] rate_in,
    output logic [RATE_W-1:0] rate_out,
    output logic [PRE_W-1:0]  pre_out
);

    // limit the request to the supported span
    always_comb begin
        if (rate_in < RATE_W'(MIN_RATE)) begin
            rate_out = RATE_W'(MIN_RATE);
        end else if (rate_in > RATE_W'(MAX_RATE)) begin
            rate_out = RATE_W'(MAX_RATE);
        end else begin
            rate_out = rate_in;
        end
    end

    // slow rates take the larger prescale
    always_comb begin
        if (rate_out <= RATE_W'(SLOW_LIMIT)) begin
            pre_out = PRE_W'(SLOW_PRE);
        end else begin
            pre_out = PRE_W'(1);
        end
    end

endmodule

// File: rtl/btg_seq_div.sv
module btg_seq_div
    import btg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);

    localparam int CNT_W = $clog2(W);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     rem_q, quo_q, den_q;
    logic [W:0]       rem_sh, rem_nx;
    logic             fits;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = DV_STEP;
        end else begin
            unique case (state_q)
                DV_IDLE: state_d = DV_IDLE;
                DV_STEP: if (cnt_q == CNT_W'(W-1)) state_d = DV_DONE;
                DV_DONE: state_d = DV_IDLE;
                default: state_d = DV_IDLE;
            endcase
        end
    end

    // one restoring step
    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        fits   = (rem_sh >= {1'b0, den_q});
        rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
        end else if (state_q == DV_STEP) begin
            cnt_q <= cnt_q + CNT_W'(1);
            rem_q <= rem_nx[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    // outputs
    always_comb begin
        done = (state_q == DV_DONE);
        quot = quo_q;
    end

endmodule

// File: rtl/btg_tick_gen.sv
module btg_tick_gen #(
    parameter int PER_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] period,
    input  logic             run,
    output logic             tick
);

    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            per_q <= period;
            cnt_q <= period - PER_W'(1);
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= per_q - PER_W'(1);
            end else begin
                cnt_q <= cnt_q - PER_W'(1);
            end
        end
    end

    always_comb begin
        tick = run && (cnt_q == '0);
    end

endmodule

// File: rtl/btg_top.sv
module btg_top
    import btg_pkg::*;
#(
    parameter int CLK_HZ     = 48_000_000,
    parameter int RATE_W     = 24,
    parameter int DIV_W      = 17,
    parameter int PRE_W      = 3,
    parameter int NUM_W      = 32,
    parameter int MIN_RATE   = 300,
    parameter int MAX_RATE   = 2_000_000,
    parameter int SLOW_LIMIT = 365,
    parameter int SLOW_PRE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    output logic              ready,
    output logic              tick,
    output logic [DIV_W-1:0]  divider,
    output logic [PRE_W-1:0]  prescale
);

    localparam int PER_W = DIV_W + PRE_W + 1;

    ctl_state_e        state_q, state_d;
    logic [RATE_W-1:0] shaped_rate;
    logic [PRE_W-1:0]  shaped_pre;
    logic [RATE_W-1:0] rate_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DIV_W-1:0]  div_out_q;
    logic [PRE_W-1:0]  pre_out_q;
    logic [NUM_W-1:0]  half_den, den, num, quot;
    logic              div_start, div_done, accept;
    logic [PER_W-1:0]  period;

    btg_req_shaper #(
        .RATE_W(RATE_W), .PRE_W(PRE_W), .MIN_RATE(MIN_RATE),
        .MAX_RATE(MAX_RATE), .SLOW_LIMIT(SLOW_LIMIT), .SLOW_PRE(SLOW_PRE)
    ) u_shaper (
        .rate_in (req_rate),
        .rate_out(shaped_rate),
        .pre_out (shaped_pre)
    );

    // operands: numerator carries half the denominator for rounding
    always_comb begin
        half_den  = NUM_W'(rate_q) * NUM_W'(pre_q);
        den       = half_den << 1;
        num       = NUM_W'(CLK_HZ) + half_den;
        div_start = (state_q == CTL_LOAD);
    end

    btg_seq_div #(.W(NUM_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (num),
        .den  (den),
        .done (div_done),
        .quot (quot)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (req_valid) begin
            state_d = CTL_LOAD;
        end else begin
            unique case (state_q)
                CTL_IDLE:   state_d = CTL_IDLE;
                CTL_LOAD:   state_d = CTL_DIVIDE;
                CTL_DIVIDE: if (div_done) state_d = CTL_RUN;
                CTL_RUN:    state_d = CTL_RUN;
                default:    state_d = CTL_IDLE;
            endcase
        end
    end

    always_comb begin
        accept = (state_q == CTL_DIVIDE) && div_done && !req_valid;
        period = PER_W'(quot[DIV_W-1:0]) * PER_W'(pre_q) * PER_W'(2);
    end

    // captured request and reported result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q    <= '0;
            pre_q     <= '0;
            div_out_q <= '0;
            pre_out_q <= '0;
        end else begin
            if (req_valid) begin
                rate_q <= shaped_rate;
                pre_q  <= shaped_pre;
            end
            if (accept) begin
                div_out_q <= quot[DIV_W-1:0];
                pre_out_q <= pre_q;
            end
        end
    end

    btg_tick_gen #(.PER_W(PER_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .period(period),
        .run   (state_q == CTL_RUN),
        .tick  (tick)
    );

    // outputs
    always_comb begin
        ready    = (state_q == CTL_RUN);
        divider  = div_out_q;
        prescale = pre_out_q;
    end

endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
    parameter int DIV_W = 17,
    parameter int PRE_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             ready,
    input logic             tick,
    input logic [DIV_W-1:0] divider,
    input logic [PRE_W-1:0] prescale
);

    AST_TICK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ready); // R8

    AST_REQ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !ready); // R7

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6

    AST_PRESCALE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (prescale == PRE_W'(1) || prescale == PRE_W'(4))); // R9

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (divider != '0)); // R4

    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ready) |-> ($stable(divider) && $stable(prescale))); // R5

endmodule

bind btg_top btg_checker #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .ready    (ready),
    .tick     (tick),
    .divider  (divider),
    .prescale (prescale)
);

// File: tb/test_btg_top.sv
module test_btg_top;
    localparam int RATE_W = 24;
    localparam int DIV_W  = 17;
    localparam int PRE_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [RATE_W-1:0] req_rate = '0;
    logic              ready, tick;
    logic [DIV_W-1:0]  divider;
    logic [PRE_W-1:0]  prescale;

    always #4 clk = ~clk;

    btg_top i_btg_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rate(req_rate),
        .ready(ready), .tick(tick), .divider(divider), .prescale(prescale)
    );

    int  total = 0;
    int  bad = 0;
    int  cycles = 0;
    bit  finished = 1'b0;

    // reference model state
    longint m_ready = 0, m_div = 0, m_pre = 0, m_wait = 0, m_phase = 0;
    longint p_div = 0, p_pre = 0;

    function automatic void shape(input longint r_in, output longint d, output longint p);
        longint r;
        r = r_in;
        if (r < 300) r = 300;
        if (r > 2000000) r = 2000000;
        p = (r <= 365) ? 4 : 1;
        d = (48000000 + p * r) / (2 * p * r);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready = 0; m_div = 0; m_pre = 0; m_wait = 0; m_phase = 0;
        end else if (req_valid) begin
            shape(longint'(req_rate), p_div, p_pre);
            m_wait = 34;
            m_ready = 0;
        end else if (m_wait > 0) begin
            m_wait = m_wait - 1;
            if (m_wait == 0) begin
                m_ready = 1; m_div = p_div; m_pre = p_pre; m_phase = 1;
            end
        end else if (m_ready != 0) begin
            m_phase = m_phase + 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            longint exp_tick;
            exp_tick = (m_ready != 0 && (m_phase % (2 * m_pre * m_div)) == 0) ? 1 : 0;
            chk("R5/R7 ready", longint'(ready), m_ready);
            chk("R6/R8 tick", longint'(tick), exp_tick);
            chk("R4 divider", longint'(divider), m_div);
            chk("R3 prescale", longint'(prescale), m_pre);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            finish_up();
        end
    end

    task automatic request(input int rate);
        @(negedge clk);
        req_valid = 1'b1;
        req_rate  = RATE_W'(rate);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R1: reset values
        chk("R1 ready", longint'(ready), 0);
        chk("R1 tick", longint'(tick), 0);
        chk("R1 divider", longint'(divider), 0);
        chk("R1 prescale", longint'(prescale), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 ready after reset", longint'(ready), 0);

        // fastest rate, period 24
        request(2000000);
        idle(33);
        chk("R5 not yet ready", longint'(ready), 0);
        idle(1);
        chk("R5 ready on edge 34", longint'(ready), 1);
        chk("R4 divider 2M", longint'(divider), 12);
        chk("R3 prescale 2M", longint'(prescale), 1);
        idle(120);

        // R7: new request while ticking holds the old values
        request(921600);
        chk("R7 ready drops", longint'(ready), 0);
        chk("R7 divider held", longint'(divider), 12);
        idle(150);
        chk("R4 divider 921600", longint'(divider), 26);

        request(115200);
        idle(900);
        chk("R4 divider 115200", longint'(divider), 208);

        // R7: restart in the middle of a division
        request(9600);
        idle(10);
        request(2000000);
        idle(25);
        chk("R7 stale result suppressed", longint'(ready), 0);
        chk("R7 divider held mid-restart", longint'(divider), 208);
        idle(60);
        chk("R7 new divider", longint'(divider), 12);

        // R2: clamping at both ends
        request(3000000);
        idle(40);
        chk("R2 high clamp divider", longint'(divider), 12);
        request(100);
        idle(40);
        chk("R2 low clamp divider", longint'(divider), 20000);
        chk("R3 low clamp prescale", longint'(prescale), 4);

        // R3: threshold pair
        request(365);
        idle(40);
        chk("R3 prescale at 365", longint'(prescale), 4);
        chk("R4 divider at 365", longint'(divider), 16438);
        request(366);
        idle(40);
        chk("R3 prescale at 366", longint'(prescale), 1);
        chk("R4 divider at 366", longint'(divider), 65574);
        chk("R9 prescale code", longint'(prescale == 1 || prescale == 4), 1);

        request(57600);
        idle(2000);
        finish_up();
    end
endmodule